// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for a signal-processing datapath. It keeps, per generator, a small bank of register sets. Each set holds an index (the running pointer), a modify value (a signed step), a base and a length. One access names a generator, an index register and a modify register of that same generator. It issues either the index itself, after which the index advances by the modify value (post-modify), or the sum of index and modify while the index stays put (pre-modify offset).

A nonzero length turns the index into a pointer that runs around a circular buffer of that many words starting at the base. Any update that leaves the window, upward or downward, is folded back by one length. A length of zero gives plain linear stepping. A modify-only operation advances an index the same way without issuing an address. Two generators are built by default, one serving data memory and one serving program memory, and the pairing of index and modify registers never crosses between them. Modify registers come out of reset holding the steps 0, +1 and -1, so common walks need no setup.

Top module: `cbuf_agen`

## Requirements
- R1: After reset `addr_valid_o` is low and every index, base and length register is zero. In each generator modify slot 1 holds +1, slot 2 holds -1 (all ones), and every other modify slot holds 0.
- R2: With `op_kind_i` = 0 (post-modify), the address issued is the selected index, and the index then becomes index plus modify, with wraparound applied.
- R3: With `op_kind_i` = 1 (pre-modify offset), the address issued is index plus modify, truncated to the address width and never wrapped, and the index keeps its value.
- R4: While the selected length register is zero, index updates are linear modulo 2^AW.
- R5: With a nonzero length L and base B, an updated index at or above B+L has L subtracted. For example B=4000, L=3, I=4002 and a step of +1 gives two post-modify addresses, 4002 and then 4000, and leaves the index at 4001.
- R6: With a nonzero length, an updated index below B has L added.
- R7: With `op_kind_i` = 2 (modify-only), the index advances as in R2 with wraparound, and `addr_valid_o` stays low in the next cycle. `op_kind_i` = 3 does nothing.
- R8: `op_gen_i` and `wr_gen_i` pick the generator. Index and modify registers are always taken from the same generator, writes to one generator leave the other untouched, and `addr_gen_o` reports the generator of the issued address.
- R9: Register writes use `wr_kind_i` 0 = index, 1 = modify, 2 = base, 3 = length. A base write also loads the index of that set with the same value. An index write leaves the base unchanged.
- R10: An access presented in one cycle shows its address with `addr_valid_o` high right after the next rising edge. Accesses may come every cycle, and each one sees the index left by the access before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_gen_i | input | $clog2(NGEN) | Generator of the write |
| wr_kind_i | input | 2 | Register kind: 0 index, 1 modify, 2 base, 3 length |
| wr_sel_i | input | $clog2(NSET) | Register set number |
| wr_data_i | input | AW | Write value |
| op_valid_i | input | 1 | Operation strobe |
| op_kind_i | input | 2 | 0 post-modify, 1 pre-modify offset, 2 modify-only, 3 none |
| op_gen_i | input | $clog2(NGEN) | Generator of the operation |
| op_isel_i | input | $clog2(NSET) | Index register number |
| op_msel_i | input | $clog2(NSET) | Modify register number |
| addr_o | output | AW | Issued address |
| addr_valid_o | output | 1 | Address strobe |
| addr_gen_o | output | $clog2(NGEN) | Generator of the issued address |

## Verification
The bench builds the block with its defaults: a 16-bit address, two generators and four register sets per generator. That width is wide enough to run the 4000-based window of R5 and R6 unchanged, and narrow enough that a linear step from 0xFFFE across the top of the address space is cheap to reach. With four sets, the preset slots (0, +1, -1) and a freely written slot 3 sit side by side. With two generators, a write to one generator can be shown to leave the same-numbered registers of the other alone.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;
  typedef enum logic [1:0] {
    OP_POST = 2'd0,
    OP_PRE  = 2'd1,
    OP_MOD  = 2'd2,
    OP_NONE = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    WR_IDX  = 2'd0,
    WR_MOD  = 2'd1,
    WR_BASE = 2'd2,
    WR_LEN  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/cbuf_wrap.sv
module cbuf_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] nxt_o,
  output logic [AW-1:0] off_o
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum, lo, ln, hi;

  always_comb begin
    sum = $signed({2'b00, idx_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});
    lo  = $signed({2'b00, base_i});
    ln  = $signed({2'b00, len_i});
    hi  = lo + ln;
    off_o = AW'(sum);
    // one correction step: the step must not exceed the length
    if (len_i == '0)   nxt_o = AW'(sum);
    else if (sum >= hi) nxt_o = AW'(sum - ln);
    else if (sum < lo)  nxt_o = AW'(sum + ln);
    else                nxt_o = AW'(sum);
  end
endmodule

// File: rtl/cbuf_regbank.sv
module cbuf_regbank
  import cbuf_agen_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NSET = 4,
  localparam int SW  = $clog2(NSET)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  wr_kind_e      wr_kind_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [SW-1:0] upd_sel_i,
  input  logic [AW-1:0] upd_val_i,
  input  logic [SW-1:0] rd_isel_i,
  input  logic [SW-1:0] rd_msel_i,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] mod_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] len_o
);
  logic [AW-1:0] idx_q  [NSET];
  logic [AW-1:0] mod_q  [NSET];
  logic [AW-1:0] base_q [NSET];
  logic [AW-1:0] len_q  [NSET];

  for (genvar s = 0; s < NSET; s++) begin : g_set
    localparam logic [AW-1:0] MOD_RST = (s == 1) ? AW'(1) :
                                        (s == 2) ? {AW{1'b1}} : '0;
    logic wr_hit, upd_hit;
    assign wr_hit  = wr_en_i  && (wr_sel_i  == SW'(s));
    assign upd_hit = upd_en_i && (upd_sel_i == SW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q[s]  <= '0;
        mod_q[s]  <= MOD_RST;
        base_q[s] <= '0;
        len_q[s]  <= '0;
      end else begin
        if (wr_hit) begin
          unique case (wr_kind_i)
            WR_IDX:  idx_q[s] <= wr_data_i;
            WR_MOD:  mod_q[s] <= wr_data_i;
            WR_BASE: begin
              base_q[s] <= wr_data_i;
              idx_q[s]  <= wr_data_i;
            end
            WR_LEN:  len_q[s] <= wr_data_i;
            default: ;
          endcase
        end
        // an index update from an operation wins over a same-cycle write
        if (upd_hit) idx_q[s] <= upd_val_i;
      end
    end
  end

  assign idx_o  = idx_q[rd_isel_i];
  assign base_o = base_q[rd_isel_i];
  assign len_o  = len_q[rd_isel_i];
  assign mod_o  = mod_q[rd_msel_i];
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
  import cbuf_agen_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NSET = 4,
  parameter int NGEN = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [$clog2(NGEN)-1:0] wr_gen_i,
  input  logic [1:0]              wr_kind_i,
  input  logic [$clog2(NSET)-1:0] wr_sel_i,
  input  logic [AW-1:0]           wr_data_i,
  input  logic                    op_valid_i,
  input  logic [1:0]              op_kind_i,
  input  logic [$clog2(NGEN)-1:0] op_gen_i,
  input  logic [$clog2(NSET)-1:0] op_isel_i,
  input  logic [$clog2(NSET)-1:0] op_msel_i,
  output logic [AW-1:0]           addr_o,
  output logic                    addr_valid_o,
  output logic [$clog2(NGEN)-1:0] addr_gen_o
);
  localparam int GW = $clog2(NGEN);

  op_kind_e op_kind;
  logic     is_access, is_update;

  assign op_kind   = op_kind_e'(op_kind_i);
  assign is_access = op_valid_i && (op_kind == OP_POST || op_kind == OP_PRE);
  assign is_update = op_valid_i && (op_kind == OP_POST || op_kind == OP_MOD);

  logic [AW-1:0] g_idx  [NGEN];
  logic [AW-1:0] g_mod  [NGEN];
  logic [AW-1:0] g_base [NGEN];
  logic [AW-1:0] g_len  [NGEN];
  logic [AW-1:0] nxt_idx, off_addr;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    cbuf_regbank #(.AW(AW), .NSET(NSET)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (wr_gen_i == GW'(g))),
      .wr_kind_i (wr_kind_e'(wr_kind_i)),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .upd_en_i  (is_update && (op_gen_i == GW'(g))),
      .upd_sel_i (op_isel_i),
      .upd_val_i (nxt_idx),
      .rd_isel_i (op_isel_i),
      .rd_msel_i (op_msel_i),
      .idx_o     (g_idx[g]),
      .mod_o     (g_mod[g]),
      .base_o    (g_base[g]),
      .len_o     (g_len[g])
    );
  end

  logic [AW-1:0] op_idx, op_mval, op_base, op_len;
  assign op_idx  = g_idx[op_gen_i];
  assign op_mval = g_mod[op_gen_i];
  assign op_base = g_base[op_gen_i];
  assign op_len  = g_len[op_gen_i];

  cbuf_wrap #(.AW(AW)) u_wrap (
    .idx_i  (op_idx),
    .mod_i  (op_mval),
    .base_i (op_base),
    .len_i  (op_len),
    .nxt_o  (nxt_idx),
    .off_o  (off_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
      addr_gen_o   <= '0;
    end else begin
      addr_valid_o <= is_access;
      if (is_access) begin
        addr_o     <= (op_kind == OP_PRE) ? off_addr : op_idx;
        addr_gen_o <= op_gen_i;
      end
    end
  end
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
  parameter int AW   = 16,
  parameter int NSET = 4,
  parameter int NGEN = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic                    op_valid_i,
  input logic [1:0]              op_kind_i,
  input logic [$clog2(NGEN)-1:0] op_gen_i,
  input logic [$clog2(NSET)-1:0] op_isel_i,
  input logic [$clog2(NSET)-1:0] op_msel_i,
  input logic [AW-1:0]           op_mval,
  input logic [AW-1:0]           op_len,
  input logic [AW-1:0]           addr_o,
  input logic                    addr_valid_o,
  input logic [$clog2(NGEN)-1:0] addr_gen_o
);
  localparam int GW = $clog2(NGEN);
  localparam int SW = $clog2(NSET);

  logic          acc;
  assign acc = op_valid_i && (op_kind_i == 2'd0 || op_kind_i == 2'd1);

  // one- and two-cycle history of operations
  logic          p1_v, p2_v, p1_wr, p2_wr;
  logic [1:0]    p1_k, p2_k;
  logic [GW-1:0] p1_g, p2_g;
  logic [SW-1:0] p1_i, p2_i, p1_m, p2_m;
  logic [AW-1:0] p1_mv, p2_mv, p1_l, p2_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_wr <= 1'b0; p2_wr <= 1'b0;
      p1_k <= '0; p2_k <= '0; p1_g <= '0; p2_g <= '0;
      p1_i <= '0; p2_i <= '0; p1_m <= '0; p2_m <= '0;
      p1_mv <= '0; p2_mv <= '0; p1_l <= '0; p2_l <= '0;
    end else begin
      p1_v <= op_valid_i; p1_wr <= wr_en_i; p1_k <= op_kind_i; p1_g <= op_gen_i;
      p1_i <= op_isel_i; p1_m <= op_msel_i; p1_mv <= op_mval; p1_l <= op_len;
      p2_v <= p1_v; p2_wr <= p1_wr; p2_k <= p1_k; p2_g <= p1_g;
      p2_i <= p1_i; p2_m <= p1_m; p2_mv <= p1_mv; p2_l <= p1_l;
    end
  end

  logic same_regs;
  assign same_regs = p1_v && p2_v && !p2_wr && (p1_g == p2_g) &&
                     (p1_i == p2_i) && (p1_m == p2_m);

  AST_ACCESS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> addr_valid_o); // R10

  AST_NO_STROBE_OTHERWISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !addr_valid_o); // R7

  AST_GEN_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (addr_gen_o == $past(op_gen_i))); // R8

  AST_PRE_INDEX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_regs && p1_k == 2'd1 && p2_k == 2'd1) |-> (addr_o == $past(addr_o))); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_regs && p1_k == 2'd0 && p2_k == 2'd0 && p2_l == '0)
      |-> (addr_o == AW'($past(addr_o) + p2_mv))); // R4
endmodule

bind cbuf_agen cbuf_agen_chk #(.AW(AW), .NSET(NSET), .NGEN(NGEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .op_valid_i   (op_valid_i),
  .op_kind_i    (op_kind_i),
  .op_gen_i     (op_gen_i),
  .op_isel_i    (op_isel_i),
  .op_msel_i    (op_msel_i),
  .op_mval      (op_mval),
  .op_len       (op_len),
  .addr_o       (addr_o),
  .addr_valid_o (addr_valid_o),
  .addr_gen_o   (addr_gen_o)
);

// File: tb/sim_cbuf_agen.sv
module sim_cbuf_agen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_gen_i = 1'b0;
  logic [1:0]    wr_kind_i = '0;
  logic [1:0]    wr_sel_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic          op_valid_i = 1'b0;
  logic [1:0]    op_kind_i = '0;
  logic          op_gen_i = 1'b0;
  logic [1:0]    op_isel_i = '0;
  logic [1:0]    op_msel_i = '0;
  logic [AW-1:0] addr_o;
  logic          addr_valid_o;
  logic          addr_gen_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cbuf_agen u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic g, input logic [1:0] k, input logic [1:0] s,
                    input logic [AW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_gen_i = g; wr_kind_i = k; wr_sel_i = s; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  // one operation; returns what the outputs show after the next edge
  task automatic op(input logic g, input logic [1:0] k, input logic [1:0] i,
                    input logic [1:0] m, output int a, output bit v, output bit og);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_kind_i = k; op_gen_i = g; op_isel_i = i; op_msel_i = m;
    @(posedge clk_i); #1;
    a = int'(addr_o); v = addr_valid_o; og = addr_gen_o;
    op_valid_i = 1'b0;
  endtask

  task automatic acc_chk(input logic g, input logic [1:0] k, input logic [1:0] i,
                         input logic [1:0] m, input int exp, input string req);
    int a; bit v, og;
    op(g, k, i, m, a, v, og);
    chk(v == 1'b1, {req, " valid"}, int'(v), 1);
    chk(a == exp, {req, " addr"}, a, exp);
  endtask

  task automatic t_reset();
    chk(addr_valid_o == 1'b0, "R1 valid low", int'(addr_valid_o), 0);
    acc_chk(0, 2'd1, 2'd0, 2'd1, 1, "R1 preset +1");
    acc_chk(0, 2'd1, 2'd0, 2'd2, 16'hFFFF, "R1 preset -1");
    acc_chk(0, 2'd1, 2'd0, 2'd0, 0, "R1 preset 0 slot0");
    acc_chk(1, 2'd1, 2'd3, 2'd3, 0, "R1 preset 0 slot3 gen1");
  endtask

  task automatic t_post_linear();
    wr(0, 2'd0, 2'd0, 16'd100);
    wr(0, 2'd1, 2'd3, 16'd5);
    acc_chk(0, 2'd0, 2'd0, 2'd3, 100, "R2 post first");
    acc_chk(0, 2'd0, 2'd0, 2'd3, 105, "R2 post second");
    acc_chk(0, 2'd0, 2'd0, 2'd3, 110, "R2 post third");
    wr(0, 2'd0, 2'd1, 16'hFFFE);
    acc_chk(0, 2'd0, 2'd1, 2'd3, 16'hFFFE, "R4 linear before top");
    acc_chk(0, 2'd0, 2'd1, 2'd3, 3, "R4 linear modulo wrap");
  endtask

  task automatic t_pre();
    wr(0, 2'd0, 2'd0, 16'd200);
    wr(0, 2'd1, 2'd3, 16'd7);
    acc_chk(0, 2'd1, 2'd0, 2'd3, 207, "R3 pre first");
    acc_chk(0, 2'd1, 2'd0, 2'd3, 207, "R3 pre repeat");
    acc_chk(0, 2'd0, 2'd0, 2'd3, 200, "R3 index held after pre");
    acc_chk(0, 2'd0, 2'd0, 2'd3, 207, "R3 post after pre");
  endtask

  task automatic t_circ_up();
    wr(0, 2'd2, 2'd2, 16'd4000);
    wr(0, 2'd3, 2'd2, 16'd3);
    wr(0, 2'd0, 2'd2, 16'd4002);
    acc_chk(0, 2'd0, 2'd2, 2'd1, 4002, "R5 up first");
    acc_chk(0, 2'd0, 2'd2, 2'd1, 4000, "R5 up wrapped");
    acc_chk(0, 2'd0, 2'd2, 2'd1, 4001, "R5 index left at 4001");
    wr(0, 2'd0, 2'd2, 16'd4002);
    acc_chk(0, 2'd1, 2'd2, 2'd1, 4003, "R3 offset not wrapped");
  endtask

  task automatic t_circ_down();
    wr(0, 2'd0, 2'd2, 16'd4000);
    acc_chk(0, 2'd0, 2'd2, 2'd2, 4000, "R6 down first");
    acc_chk(0, 2'd0, 2'd2, 2'd2, 4002, "R6 down wrapped");
    acc_chk(0, 2'd0, 2'd2, 2'd2, 4001, "R6 down third");
  endtask

  task automatic t_modonly();
    int a; bit v, og;
    wr(0, 2'd2, 2'd3, 16'd10);
    wr(0, 2'd3, 2'd3, 16'd4);
    wr(0, 2'd1, 2'd3, 16'd3);
    op(0, 2'd2, 2'd3, 2'd3, a, v, og);
    chk(v == 1'b0, "R7 no strobe on modify-only", int'(v), 0);
    acc_chk(0, 2'd0, 2'd3, 2'd3, 13, "R7 index advanced");
    op(0, 2'd2, 2'd3, 2'd3, a, v, og);
    chk(v == 1'b0, "R7 no strobe second", int'(v), 0);
    acc_chk(0, 2'd0, 2'd3, 2'd3, 11, "R7 modify-only wraps");
    op(0, 2'd3, 2'd3, 2'd3, a, v, og);
    chk(v == 1'b0, "R7 kind 3 no strobe", int'(v), 0);
    acc_chk(0, 2'd1, 2'd3, 2'd0, 10, "R7 kind 3 leaves index");
  endtask

  task automatic t_gen();
    int a; bit v, og;
    wr(0, 2'd0, 2'd0, 16'd50);
    wr(1, 2'd0, 2'd0, 16'd500);
    wr(1, 2'd1, 2'd1, 16'd9);
    op(1, 2'd1, 2'd0, 2'd1, a, v, og);
    chk(a == 509, "R8 gen1 own modify", a, 509);
    chk(og == 1'b1, "R8 tag gen1", int'(og), 1);
    op(0, 2'd1, 2'd0, 2'd1, a, v, og);
    chk(a == 51, "R8 gen0 untouched by gen1 writes", a, 51);
    chk(og == 1'b0, "R8 tag gen0", int'(og), 0);
  endtask

  task automatic t_base_load();
    wr(0, 2'd2, 2'd1, 16'd300);
    acc_chk(0, 2'd0, 2'd1, 2'd0, 300, "R9 base write loads index");
    wr(0, 2'd3, 2'd1, 16'd20);
    wr(0, 2'd0, 2'd1, 16'd310);
    wr(0, 2'd1, 2'd3, 16'd15);
    acc_chk(0, 2'd0, 2'd1, 2'd3, 310, "R9 index write");
    acc_chk(0, 2'd0, 2'd1, 2'd3, 305, "R9 base kept at 300");
  endtask

  task automatic t_b2b();
    wr(0, 2'd0, 2'd0, 16'd1000);
    wr(0, 2'd3, 2'd0, 16'd0);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_kind_i = 2'd0; op_gen_i = 1'b0; op_isel_i = 2'd0; op_msel_i = 2'd1;
    @(posedge clk_i); #1;
    chk(addr_valid_o && addr_o == 16'd1000, "R10 b2b first", int'(addr_o), 1000);
    @(posedge clk_i); #1;
    chk(addr_valid_o && addr_o == 16'd1001, "R10 b2b second", int'(addr_o), 1001);
    op_valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk(addr_valid_o == 1'b0, "R10 strobe drops", int'(addr_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(addr_valid_o == 1'b0, "R1 valid in reset", int'(addr_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_post_linear();
    t_pre();
    t_circ_up();
    t_circ_down();
    t_modonly();
    t_gen();
    t_base_load();
    t_b2b();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule